// File: doc/BRIEF.md
# Receive FIFO bus readout controller

This block drains a packet receive buffer onto a host-side burst bus. A write port, standing in for the line-side receive logic, pushes packet data as 32-bit lanes with byte enables and an end-of-packet mark. At the end of each packet the same port supplies a status record holding the line byte count and a set of address-type and error flags. Lanes go into a data FIFO and records go into a small side FIFO.

The block raises a receive-ready flag when enough of the head packet is buffered. The host answers with a one-cycle select strobe, and the block then runs a burst of bus accesses on consecutive cycles. The bus is 64 bits wide, or 32 bits in narrow mode. The block marks end of packet on the access that carries the last byte. It can then follow that access with one extra access carrying a packed 32-bit status word. An optional header mode raises ready as soon as a programmable header is buffered, and it trims the first burst of the packet to that header.

Top module: `rxb_readout`

## Requirements
- R1: After reset `rx_rdy` is low. Outside a burst, `rx_rdy` is high when any of these holds: the buffered byte count reaches `cfg_thresh`, a complete packet is buffered, or a status access is still owed. During a burst `rx_rdy` is low.
- R2: With `cfg_hdr_mode` set, `rx_rdy` also goes high once at least `cfg_hdr_size` bytes of a packet are buffered, provided none of that packet has been read yet. The first burst of each packet ends after the access that brings the bytes sent in that burst to `cfg_hdr_size` or more.
- R3: A `rd_sel` pulse taken while `rx_rdy` is high starts a burst. Its accesses run on consecutive cycles from the next cycle. A burst holds at most BURST accesses. It also ends when no buffered lane remains: that cycle has `bus_valid` low.
- R4: In wide mode (`cfg_wide`=1) one access carries two lanes of the same packet, the earlier written on bits 31:0 with its byte enables on `bus_be[3:0]`. The second lane is taken only if the first is not the packet's last lane and it is already buffered; otherwise bits 63:32 and `bus_be[7:4]` are zero. In narrow mode one lane is carried per access and the upper half is zero.
- R5: `bus_eop` is high on the data access that carries the packet's last lane.
- R6: With `cfg_stat_en` set, the access right after an end-of-packet access in the same burst is a status access, marked by `bus_stat`=1, and it ends the burst.
- R7: If the end-of-packet access is the last one a burst allows, the burst ends there and `rx_rdy` is high on the next cycle. The next burst is then a single status access.
- R8: Status word layout: length on 31:16, multicast on 10, broadcast on 9, receive-ok on 8, flow-control on 7, line error on 5, too-long on 4, too-short on 3, CRC error on 1, overflow on 0. These come from `wr_flags` bits 8,7,6,5,4,3,2,1,0 in that order. Bits 15:11, 6 and 2 are zero. The word sits on bits 31:0 and is repeated on 63:32 in wide mode. In narrow mode the upper half is zero. `bus_be` has no meaning during a status access.
- R9: The status length field is the `wr_len` value given with the packet, whatever the number of bytes moved on the bus.
- R10: With `cfg_stat_en` clear, no status access is made. A packet's record is dropped at its end-of-packet access, and the next packet may start in a later burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cfg_wide | input | 1 | 1: 64-bit bus, 0: 32-bit narrow bus |
| cfg_stat_en | input | 1 | Append a status access after each packet |
| cfg_hdr_mode | input | 1 | Enable header-ready mode |
| cfg_thresh | input | CFG_W | Ready threshold in bytes |
| cfg_hdr_size | input | CFG_W | Header size in bytes |
| wr_valid | input | 1 | Write a lane |
| wr_data | input | 32 | Lane data, byte 0 in bits 7:0 |
| wr_be | input | 4 | Lane byte enables, contiguous from bit 0, never zero |
| wr_last | input | 1 | Lane is the packet's last; status record written with it |
| wr_len | input | 16 | Line byte count of the packet (valid with wr_last) |
| wr_flags | input | 9 | Packet flags as listed in R8 (valid with wr_last) |
| rx_rdy | output | 1 | Receive ready |
| rd_sel | input | 1 | Host select strobe, one cycle |
| bus_valid | output | 1 | Access present on the bus |
| bus_data | output | 64 | Bus data |
| bus_be | output | 8 | Bus byte enables |
| bus_eop | output | 1 | Access carries the packet's last lane |
| bus_stat | output | 1 | Access is a status access |

## Verification
The assertions take for granted that the write port never pushes into a full data FIFO. They also take for granted that it never ends a packet while the record FIFO is full, that `rd_sel` comes only while `rx_rdy` is high, and that the configuration inputs stay still while packets are in flight. The stimulus keeps to these rules. The bench tracks its own model occupancy and holds back a write that would exceed either depth. It raises the strobe only when its model expects ready and no burst is running. It changes configuration only after every packet of a phase has drained.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef struct packed {
    logic        last;
    logic [3:0]  be;
    logic [31:0] data;
  } lane_t;

  // flags: [8] mcast [7] bcast [6] rx ok [5] flow ctl [4] line err
  //        [3] too long [2] too short [1] crc err [0] overflow
  typedef struct packed {
    logic [15:0] len;
    logic [8:0]  flags;
  } srec_t;

  function automatic logic [2:0] lane_bytes(input logic [3:0] be);
    return 3'(be[0]) + 3'(be[1]) + 3'(be[2]) + 3'(be[3]);
  endfunction

  function automatic logic [31:0] pack_status(input srec_t r);
    return {r.len, 5'b0, r.flags[8:6], r.flags[5], 1'b0,
            r.flags[4:2], 1'b0, r.flags[1:0]};
  endfunction

endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic [1:0]                 pop_num,
  output logic [W-1:0]               rd0,
  output logic [W-1:0]               rd1,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_d;

  always_comb begin
    wp_d  = wp_q + AW'(push);
    rp_d  = rp_q + AW'(pop_num);
    cnt_d = count + CW'(push) - CW'(pop_num);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  assign rd0 = mem[rp_q];
  assign rd1 = mem[rp_q + AW'(1)];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CW'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_num) <= count); // R3

endmodule

// File: rtl/rxb_burst_ctl.sv
module rxb_burst_ctl
  import rxb_pkg::*;
#(
  parameter int BURST = 4,
  parameter int CFG_W = 8,
  parameter int LCW   = 5,
  parameter int RCW   = 3,
  parameter int BCW   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide,
  input  logic             cfg_stat_en,
  input  logic             cfg_hdr_mode,
  input  logic [CFG_W-1:0] cfg_thresh,
  input  logic [CFG_W-1:0] cfg_hdr_size,
  input  logic             rd_sel,
  input  lane_t            lane0,
  input  lane_t            lane1,
  input  logic [LCW-1:0]   lane_cnt,
  input  srec_t            rec,
  input  logic [RCW-1:0]   rec_cnt,
  input  logic [BCW-1:0]   byte_cnt,
  output logic             rx_rdy,
  output logic             bus_valid,
  output logic [63:0]      bus_data,
  output logic [7:0]       bus_be,
  output logic             bus_eop,
  output logic             bus_stat,
  output logic [1:0]       lane_pop,
  output logic             rec_pop,
  output logic [3:0]       rd_bytes
);
  localparam int BW = $clog2(BURST + 1);
  localparam int SW = CFG_W + 1;

  typedef enum logic {S_IDLE, S_BURST} st_t;

  st_t           st_q, st_d;
  logic [BW-1:0] beat_q, beat_d;
  logic [SW-1:0] sent_q, sent_d;
  logic          pend_q, pend_d;
  logic          started_q, started_d;
  logic          cap_q, cap_d;
  logic          take2;
  logic [31:0]   swd;

  always_comb begin
    st_d      = st_q;
    beat_d    = beat_q;
    sent_d    = sent_q;
    pend_d    = pend_q;
    started_d = started_q;
    cap_d     = cap_q;
    bus_valid = 1'b0;
    bus_data  = '0;
    bus_be    = '0;
    bus_eop   = 1'b0;
    bus_stat  = 1'b0;
    lane_pop  = 2'd0;
    rec_pop   = 1'b0;
    rd_bytes  = '0;
    take2     = 1'b0;
    swd       = pack_status(rec);

    rx_rdy = (st_q == S_IDLE) &&
             (pend_q || (rec_cnt != '0) || (int'(byte_cnt) >= int'(cfg_thresh)) ||
              (cfg_hdr_mode && !started_q && (byte_cnt != '0) &&
               (int'(byte_cnt) >= int'(cfg_hdr_size))));

    if (st_q == S_IDLE) begin
      if (rd_sel && rx_rdy) begin
        st_d   = S_BURST;
        beat_d = '0;
        sent_d = '0;
        cap_d  = cfg_hdr_mode && !started_q;
      end
    end else if (pend_q) begin
      bus_valid = 1'b1;
      bus_stat  = 1'b1;
      bus_data  = cfg_wide ? {swd, swd} : {32'h0, swd};
      rec_pop   = 1'b1;
      pend_d    = 1'b0;
      st_d      = S_IDLE;
    end else if (lane_cnt != '0) begin
      take2          = cfg_wide && !lane0.last && (lane_cnt >= LCW'(2));
      bus_valid      = 1'b1;
      bus_data[31:0] = lane0.data;
      bus_be[3:0]    = lane0.be;
      bus_eop        = lane0.last;
      rd_bytes       = {1'b0, lane_bytes(lane0.be)};
      lane_pop       = 2'd1;
      if (take2) begin
        bus_data[63:32] = lane1.data;
        bus_be[7:4]     = lane1.be;
        bus_eop         = lane1.last;
        rd_bytes        = rd_bytes + {1'b0, lane_bytes(lane1.be)};
        lane_pop        = 2'd2;
      end
      beat_d    = beat_q + BW'(1);
      sent_d    = sent_q + SW'(rd_bytes);
      started_d = 1'b1;
      if (bus_eop) begin
        started_d = 1'b0;
        if (cfg_stat_en) begin
          pend_d = 1'b1;
          if (beat_d == BW'(BURST)) st_d = S_IDLE;
        end else begin
          rec_pop = 1'b1;
          st_d    = S_IDLE;
        end
      end else if ((beat_d == BW'(BURST)) ||
                   (cap_q && (int'(sent_d) >= int'(cfg_hdr_size)))) begin
        st_d = S_IDLE;
      end
    end else begin
      st_d = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      beat_q    <= '0;
      sent_q    <= '0;
      pend_q    <= 1'b0;
      started_q <= 1'b0;
      cap_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      beat_q    <= beat_d;
      sent_q    <= sent_d;
      pend_q    <= pend_d;
      started_q <= started_d;
      cap_q     <= cap_d;
    end
  end

  AST_SEL_WHEN_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> rx_rdy); // R1
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BURST) |-> (beat_q < BW'(BURST))); // R3
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !cfg_wide) |-> ((bus_data[63:32] == 32'h0) && (bus_be[7:4] == 4'h0))); // R4
  AST_STAT_FOLLOWS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_eop && cfg_stat_en && (beat_q != BW'(BURST - 1)))
      |=> (bus_valid && bus_stat)); // R6
  AST_DEFER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_eop && cfg_stat_en && (beat_q == BW'(BURST - 1)))
      |=> (rx_rdy && !bus_valid)); // R7
  AST_STAT_HAS_REC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stat |-> (rec_cnt != '0)); // R8

endmodule

// File: rtl/rxb_readout.sv
module rxb_readout
  import rxb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SDEPTH = 4,
  parameter int BURST  = 4,
  parameter int CFG_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide,
  input  logic             cfg_stat_en,
  input  logic             cfg_hdr_mode,
  input  logic [CFG_W-1:0] cfg_thresh,
  input  logic [CFG_W-1:0] cfg_hdr_size,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       wr_be,
  input  logic             wr_last,
  input  logic [15:0]      wr_len,
  input  logic [8:0]       wr_flags,
  output logic             rx_rdy,
  input  logic             rd_sel,
  output logic             bus_valid,
  output logic [63:0]      bus_data,
  output logic [7:0]       bus_be,
  output logic             bus_eop,
  output logic             bus_stat
);
  localparam int LCW   = $clog2(DEPTH) + 1;
  localparam int RCW   = $clog2(SDEPTH) + 1;
  localparam int CNT_W = $clog2(DEPTH * 4 + 1);
  localparam int LW    = $bits(lane_t);
  localparam int RW    = $bits(srec_t);

  logic [1:0]       rs_q;
  logic             rst_core_n;
  lane_t            lane_in, lane0, lane1;
  srec_t            rec_in, rec0, rec_nxt_unused;
  logic [LCW-1:0]   lane_cnt;
  logic [RCW-1:0]   rec_cnt;
  logic [1:0]       lane_pop;
  logic             rec_pop;
  logic [3:0]       rd_bytes;
  logic [2:0]       wr_bytes;
  logic [CNT_W-1:0] byte_q, byte_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign lane_in = '{last: wr_last, be: wr_be, data: wr_data};
  assign rec_in  = '{len: wr_len, flags: wr_flags};

  rxb_fifo #(.W(LW), .DEPTH(DEPTH)) i_lane_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(wr_valid), .wdata(lane_in),
    .pop_num(lane_pop), .rd0(lane0), .rd1(lane1), .count(lane_cnt));

  rxb_fifo #(.W(RW), .DEPTH(SDEPTH)) i_rec_fifo (
    .clk(clk), .rst_n(rst_core_n), .push(wr_valid && wr_last), .wdata(rec_in),
    .pop_num({1'b0, rec_pop}), .rd0(rec0), .rd1(rec_nxt_unused), .count(rec_cnt));

  always_comb begin
    wr_bytes = wr_valid ? lane_bytes(wr_be) : 3'd0;
    byte_d   = byte_q + CNT_W'(wr_bytes) - CNT_W'(rd_bytes);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) byte_q <= '0;
    else             byte_q <= byte_d;
  end

  rxb_burst_ctl #(.BURST(BURST), .CFG_W(CFG_W), .LCW(LCW), .RCW(RCW), .BCW(CNT_W)) i_ctl (
    .clk(clk), .rst_n(rst_core_n),
    .cfg_wide(cfg_wide), .cfg_stat_en(cfg_stat_en), .cfg_hdr_mode(cfg_hdr_mode),
    .cfg_thresh(cfg_thresh), .cfg_hdr_size(cfg_hdr_size), .rd_sel(rd_sel),
    .lane0(lane0), .lane1(lane1), .lane_cnt(lane_cnt), .rec(rec0), .rec_cnt(rec_cnt),
    .byte_cnt(byte_q), .rx_rdy(rx_rdy), .bus_valid(bus_valid), .bus_data(bus_data),
    .bus_be(bus_be), .bus_eop(bus_eop), .bus_stat(bus_stat), .lane_pop(lane_pop),
    .rec_pop(rec_pop), .rd_bytes(rd_bytes));

  AST_BYTES_MATCH_LANES: assert property (@(posedge clk) disable iff (!rst_core_n)
    (byte_q == '0) |-> (lane_cnt == '0)); // R1
  AST_REC_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_valid && wr_last) |-> (rec_cnt < RCW'(SDEPTH))); // R10

endmodule

// File: tb/test_rxb_readout.sv
module test_rxb_readout;
  localparam int DEPTH = 16, SDEPTH = 4, BURST = 4, CFG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wide = 1'b0, cfg_stat_en = 1'b1, cfg_hdr_mode = 1'b0;
  logic [CFG_W-1:0] cfg_thresh = 8'd8, cfg_hdr_size = 8'd8;
  logic wr_valid = 1'b0, wr_last = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_be = '0;
  logic [15:0] wr_len = '0;
  logic [8:0] wr_flags = '0;
  logic rx_rdy, bus_valid, bus_eop, bus_stat;
  logic [63:0] bus_data;
  logic [7:0] bus_be;

  always #10 clk = ~clk;

  rxb_readout #(.DEPTH(DEPTH), .SDEPTH(SDEPTH), .BURST(BURST), .CFG_W(CFG_W)) i_rxb_readout (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_stat_en(cfg_stat_en),
    .cfg_hdr_mode(cfg_hdr_mode), .cfg_thresh(cfg_thresh), .cfg_hdr_size(cfg_hdr_size),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_be(wr_be), .wr_last(wr_last),
    .wr_len(wr_len), .wr_flags(wr_flags), .rx_rdy(rx_rdy), .rd_sel(rd_sel),
    .bus_valid(bus_valid), .bus_data(bus_data), .bus_be(bus_be),
    .bus_eop(bus_eop), .bus_stat(bus_stat));

  typedef struct {
    logic [31:0] d;
    logic [3:0]  be;
    bit          last;
    logic [15:0] len;
    logic [8:0]  fl;
  } wword_t;

  wword_t wq[$];
  wword_t mq[$];
  wword_t mrec[$];
  int  mbytes = 0, m_beat = 0, m_sent = 0;
  bit  m_burst = 0, m_pend = 0, m_started = 0, m_cap = 0;
  int  n_tests = 0, n_fail = 0, cyc = 0, gap = 1;
  bit  done = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int cnt4(input logic [3:0] b);
    return int'(b[0]) + int'(b[1]) + int'(b[2]) + int'(b[3]);
  endfunction

  function automatic logic [31:0] exp_status(input logic [15:0] len, input logic [8:0] f);
    logic [31:0] w = '0;
    w[31:16] = len;
    w[10] = f[8]; w[9] = f[7]; w[8] = f[6]; w[7] = f[5];
    w[5] = f[4]; w[4] = f[3]; w[3] = f[2]; w[1] = f[1]; w[0] = f[0];
    return w;
  endfunction

  task automatic add_pkt(input int nbytes, input int len, input logic [8:0] fl);
    int nw = (nbytes + 3) / 4;
    for (int i = 0; i < nw; i++) begin
      wword_t w;
      int rem = nbytes - 4 * i;
      w.d    = $urandom();
      w.be   = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
      w.last = (i == nw - 1);
      w.len  = 16'(len);
      w.fl   = fl;
      wq.push_back(w);
    end
  endtask

  task automatic step();
    bit e_rdy, e_v, e_eop, e_st, take2, push, sel;
    logic [63:0] e_d;
    logic [7:0] e_be;
    logic [31:0] sw;
    int nb;
    wword_t w0, w1, wn;
    e_rdy = !m_burst && (m_pend || (mrec.size() > 0) || (mbytes >= int'(cfg_thresh)) ||
            (cfg_hdr_mode && !m_started && mbytes > 0 && mbytes >= int'(cfg_hdr_size)));
    e_v = 0; e_eop = 0; e_st = 0; e_d = '0; e_be = '0; take2 = 0; nb = 0;
    if (m_burst) begin
      if (m_pend) begin
        e_v = 1; e_st = 1;
        sw = exp_status(mrec[0].len, mrec[0].fl);
        e_d = cfg_wide ? {sw, sw} : {32'h0, sw};
      end else if (mq.size() > 0) begin
        w0 = mq[0];
        take2 = cfg_wide && !w0.last && (mq.size() > 1);
        e_v = 1; e_d[31:0] = w0.d; e_be[3:0] = w0.be; e_eop = w0.last; nb = cnt4(w0.be);
        if (take2) begin
          w1 = mq[1];
          e_d[63:32] = w1.d; e_be[7:4] = w1.be; e_eop = w1.last; nb += cnt4(w1.be);
        end
      end
    end
    chk(m_pend ? "R7" : (cfg_hdr_mode ? "R2" : "R1"), "rx_rdy", 64'(rx_rdy), 64'(e_rdy));
    chk("R3", "bus_valid", 64'(bus_valid), 64'(e_v));
    if (e_v) begin
      chk(cfg_stat_en ? "R6" : "R10", "bus_stat", 64'(bus_stat), 64'(e_st));
      if (e_st) begin
        chk("R9", "status length", 64'(bus_data[31:16]), 64'(e_d[31:16]));
        chk("R8", "status word", bus_data, e_d);
      end else begin
        chk("R4", "data", bus_data, e_d);
        chk("R4", "byte enables", 64'(bus_be), 64'(e_be));
        chk("R5", "eop", 64'(bus_eop), 64'(e_eop));
      end
    end
    sel  = !m_burst && e_rdy;
    push = (wq.size() > 0) && (cyc % gap == 0) && (mq.size() < DEPTH) &&
           (!wq[0].last || mrec.size() < SDEPTH);
    rd_sel = sel;
    if (push) begin
      wn = wq.pop_front();
      wr_valid = 1'b1; wr_data = wn.d; wr_be = wn.be; wr_last = wn.last;
      wr_len = wn.len; wr_flags = wn.fl;
    end else begin
      wr_valid = 1'b0; wr_last = 1'b0;
    end
    if (m_burst) begin
      if (m_pend) begin
        void'(mrec.pop_front()); m_pend = 0; m_burst = 0;
      end else if (mq.size() > 0) begin
        void'(mq.pop_front());
        if (take2) void'(mq.pop_front());
        mbytes -= nb; m_beat++; m_sent += nb; m_started = 1;
        if (e_eop) begin
          m_started = 0;
          if (cfg_stat_en) begin
            m_pend = 1;
            if (m_beat == BURST) m_burst = 0;
          end else begin
            void'(mrec.pop_front()); m_burst = 0;
          end
        end else if (m_beat == BURST || (m_cap && m_sent >= int'(cfg_hdr_size))) begin
          m_burst = 0;
        end
      end else begin
        m_burst = 0;
      end
    end else if (sel) begin
      m_burst = 1; m_beat = 0; m_sent = 0; m_cap = cfg_hdr_mode && !m_started;
    end
    if (push) begin
      mq.push_back(wn);
      mbytes += cnt4(wn.be);
      if (wn.last) mrec.push_back(wn);
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_phase(input string req);
    int c = 0;
    bit drained;
    while ((wq.size() > 0 || mq.size() > 0 || mrec.size() > 0 || m_pend || m_burst) && c < 3000) begin
      step();
      c++;
    end
    drained = (wq.size() == 0 && mq.size() == 0 && mrec.size() == 0 && !m_pend && !m_burst);
    chk(req, "phase drained", 64'(drained), 64'd1);
    repeat (3) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "rx_rdy after reset", 64'(rx_rdy), 64'd0);
    chk("R3", "bus_valid after reset", 64'(bus_valid), 64'd0);

    // narrow, status appended; 16-byte packet ends on the last beat (R7)
    cfg_wide = 0; cfg_stat_en = 1; cfg_hdr_mode = 0; cfg_thresh = 8'd8; gap = 1;
    add_pkt(10, 10, 9'h040);
    add_pkt(16, 16, 9'h140);
    add_pkt(5, 5, 9'h0C0);
    run_phase("R6");

    // wide; 32-byte packet fills a whole burst (R7), partial lanes (R4)
    cfg_wide = 1; cfg_thresh = 8'd16; gap = 2;
    add_pkt(13, 13, 9'h040);
    add_pkt(32, 32, 9'h060);
    add_pkt(20, 20, 9'h050);
    add_pkt(4, 4, 9'h041);
    run_phase("R4");

    // status disabled (R10)
    cfg_stat_en = 0; cfg_thresh = 8'd8; gap = 1;
    add_pkt(9, 9, 9'h040);
    add_pkt(24, 24, 9'h040);
    add_pkt(3, 3, 9'h040);
    run_phase("R10");

    // header mode, narrow, slow writer (R2)
    cfg_stat_en = 1; cfg_wide = 0; cfg_hdr_mode = 1; cfg_hdr_size = 8'd8; cfg_thresh = 8'd48; gap = 3;
    add_pkt(30, 30, 9'h040);
    run_phase("R2");

    // header mode, wide, first burst trimmed to header (R2)
    cfg_wide = 1; cfg_hdr_size = 8'd12; cfg_thresh = 8'd60; gap = 2;
    add_pkt(40, 40, 9'h040);
    add_pkt(6, 6, 9'h080);
    run_phase("R2");

    // length independent of bytes moved, all flags set (R9, R8)
    cfg_hdr_mode = 0; cfg_wide = 0; cfg_thresh = 8'd4; gap = 1;
    add_pkt(12, 1500, 9'h003);
    add_pkt(6, 64, 9'h1FF);
    cfg_wide = 0;
    run_phase("R9");
    cfg_wide = 1;
    add_pkt(7, 777, 9'h1FF);
    run_phase("R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule